// File: doc/BRIEF.md
# PHY Management Bus Master

This block is the master side of a narrow management bus used to read and write registers inside PHY devices. Address and data travel on one shared 8-bit bus. A transaction starts with the address driven onto the bus, captured by the peripheral on the falling edge of an address-latch pulse. The data then follows on the same lines, driven by the master for a write or by the peripheral for a read. Two active-low chip selects choose the target device, and separate active-low read and write strobes mark the data phase.

A host-side request port takes a direction bit, a chip index, an address and write data under a valid/ready handshake. It returns the read data with a one-cycle done pulse. Every phase length is a parameter in core clock cycles, derived from nanosecond minima that assume a 12.5 ns core clock. The shared bus is split into output, output-enable and input signals for a pad-level tri-state buffer. The block also holds a software-set PHY reset level and passes the PHY interrupt line through a two-flop synchronizer.

Top module: `phy_mbus_master`

## Requirements
- R1: After synchronous reset: `req_ready`=1, `mb_cs_n`=2'b11, `mb_ale`=0, `mb_rd_n`=1, `mb_wr_n`=1, `mb_ad_oe`=0, `rsp_done`=0, `phy_rst`=1 and `phy_int`=0.
- R2: `mb_ale` is high for exactly 2 consecutive cycles, once per transaction.
- R3: The chip select is low and the address is driven (`mb_ad_oe`=1) for 3 cycles before `mb_ale` falls. The address stays on `mb_ad_out` for 1 cycle after the fall.
- R4: On a write (`req_write`=1), `mb_wr_n` is low for exactly 17 cycles and rises 18 cycles after `mb_ale` falls. The write data is on `mb_ad_out` with `mb_ad_oe`=1 for the whole strobe and 1 cycle past its rising edge.
- R5: The chip select stays low for exactly 23 cycles on a write and 24 cycles on a read.
- R6: Exactly one chip select is low in a transaction. `req_chip`=0 selects `mb_cs_n[0]` and `req_chip`=1 selects `mb_cs_n[1]`.
- R7: On a read (`req_write`=0), `mb_rd_n` is low for exactly 19 cycles and rises 20 cycles after `mb_ale` falls. `rsp_rdata` is `mb_ad_in` as sampled on the clock edge that releases the chip select.
- R8: `rsp_done` is a single-cycle pulse. It is high in the first cycle after the chip select releases, once per transaction.
- R9: `mb_ad_oe` is 0 whenever `mb_rd_n` is low, and it is 1 whenever `mb_wr_n` is low.
- R10: `req_ready` is low from acceptance until `rsp_done`. A request held valid while the block is busy is accepted later and is never lost.
- R11: `phy_rst` is 1 after reset. A cycle with `phy_rst_we`=1 loads `phy_rst_val` on the next edge. Otherwise `phy_rst` holds its value.
- R12: `phy_int` follows `phy_int_in` after exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_chip | input | 1 | Target chip index |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with done |
| mb_ale | output | 1 | Address latch strobe |
| mb_cs_n | output | 2 | Active-low chip selects |
| mb_rd_n | output | 1 | Active-low read strobe |
| mb_wr_n | output | 1 | Active-low write strobe |
| mb_ad_out | output | 8 | Shared bus output value |
| mb_ad_oe | output | 1 | Shared bus output enable |
| mb_ad_in | input | 8 | Shared bus input value |
| phy_rst_we | input | 1 | Load strobe for the reset level |
| phy_rst_val | input | 1 | New reset level |
| phy_rst | output | 1 | PHY reset output |
| phy_int_in | input | 1 | Asynchronous PHY interrupt |
| phy_int | output | 1 | Synchronized interrupt |

## Verification
The bench counts the strobe widths and the spacing from the address-latch fall to each rising strobe, because an off-by-one phase counter or a wrong max-of-constraints formula would shorten a pulse below its nanosecond minimum. A PHY model latches the address at the strobe fall and stores write data at the write-strobe rise. Reading back from both chips then exposes a swapped chip select, data sampled one edge late, or address and data phases overlapping on the bus. It also holds a request valid during a busy transaction; a handshake that drops or duplicates requests would show the wrong number of done pulses and the wrong memory contents.

// File: rtl/phy_mbus_pkg.sv
package phy_mbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_ALE,
    ST_AHOLD,
    ST_WSTRB,
    ST_WTAIL,
    ST_RSTRB,
    ST_RTAIL
  } mbus_st_e;

  function automatic int imax3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/mbus_phase_cnt.sv
module mbus_phase_cnt #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import phy_mbus_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_CS     = 2,
  parameter int CHIP_W     = 1,
  parameter int CS_SU      = 2,
  parameter int ADDR_SU    = 3,
  parameter int ALE_W      = 2,
  parameter int ADDR_HOLD  = 1,
  parameter int WR_W       = 14,
  parameter int WR_RISE    = 18,
  parameter int WR_DSU     = 15,
  parameter int WR_DHOLD   = 1,
  parameter int WR_CS_RISE = 20,
  parameter int WR_CS_W    = 22,
  parameter int RD_W       = 15,
  parameter int RD_RISE    = 20,
  parameter int RD_CS_RISE = 18,
  parameter int RD_CS_W    = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CHIP_W-1:0] req_chip,
  input  logic [DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mb_ale,
  output logic [NUM_CS-1:0] mb_cs_n,
  output logic              mb_rd_n,
  output logic              mb_wr_n,
  output logic [DATA_W-1:0] mb_ad_out,
  output logic              mb_ad_oe,
  input  logic [DATA_W-1:0] mb_ad_in
);
  // Phase lengths in cycles, each the largest of the minima that bound it.
  localparam int LEAD_LEN  = imax3(1, ADDR_SU - ALE_W, CS_SU - ALE_W);
  localparam int WR_LEN    = imax3(WR_W, WR_RISE - ADDR_HOLD, WR_DSU);
  localparam int WT_LEN    = imax3(WR_DHOLD, WR_CS_RISE - ADDR_HOLD - WR_LEN,
                                   WR_CS_W - LEAD_LEN - ALE_W - ADDR_HOLD - WR_LEN);
  localparam int RD_LEN    = imax3(RD_W, RD_RISE - ADDR_HOLD, 1);
  localparam int RT_LEN    = imax3(1, RD_CS_RISE - ADDR_HOLD - RD_LEN,
                                   RD_CS_W - LEAD_LEN - ALE_W - ADDR_HOLD - RD_LEN);
  localparam int MAX_LEN   = imax3(imax3(LEAD_LEN, ALE_W, ADDR_HOLD),
                                   imax3(WR_LEN, WT_LEN, 1), imax3(RD_LEN, RT_LEN, 1));
  localparam int CW        = $clog2(MAX_LEN + 1);

  mbus_st_e          st, st_n;
  logic              zero, load;
  logic [CW-1:0]     load_val;
  logic              wr_q;
  logic [CHIP_W-1:0] chip_q, chip_n;
  logic [DATA_W-1:0] addr_q, addr_n, wdata_q;
  logic              accept;

  assign accept = (st == ST_IDLE) && req_valid;

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE:  if (req_valid) st_n = ST_LEAD;
      ST_LEAD:  if (zero) st_n = ST_ALE;
      ST_ALE:   if (zero) st_n = ST_AHOLD;
      ST_AHOLD: if (zero) st_n = wr_q ? ST_WSTRB : ST_RSTRB;
      ST_WSTRB: if (zero) st_n = ST_WTAIL;
      ST_WTAIL: if (zero) st_n = ST_IDLE;
      ST_RSTRB: if (zero) st_n = ST_RTAIL;
      ST_RTAIL: if (zero) st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_n)
      ST_LEAD:  load_val = CW'(LEAD_LEN - 1);
      ST_ALE:   load_val = CW'(ALE_W - 1);
      ST_AHOLD: load_val = CW'(ADDR_HOLD - 1);
      ST_WSTRB: load_val = CW'(WR_LEN - 1);
      ST_WTAIL: load_val = CW'(WT_LEN - 1);
      ST_RSTRB: load_val = CW'(RD_LEN - 1);
      ST_RTAIL: load_val = CW'(RT_LEN - 1);
      default:  load_val = '0;
    endcase
  end

  assign load = (st_n != st);

  mbus_phase_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .zero     (zero)
  );

  assign chip_n = accept ? req_chip : chip_q;
  assign addr_n = accept ? req_addr : addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      wr_q    <= 1'b0;
      chip_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st <= st_n;
      if (accept) begin
        wr_q    <= req_write;
        chip_q  <= req_chip;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  // Registered bus outputs decoded from the next state.
  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b1;
      mb_cs_n   <= '1;
      mb_ale    <= 1'b0;
      mb_rd_n   <= 1'b1;
      mb_wr_n   <= 1'b1;
      mb_ad_oe  <= 1'b0;
      mb_ad_out <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      req_ready <= (st_n == ST_IDLE);
      for (int i = 0; i < NUM_CS; i++)
        mb_cs_n[i] <= !((st_n != ST_IDLE) && (chip_n == CHIP_W'(i)));
      mb_ale   <= (st_n == ST_ALE);
      mb_wr_n  <= (st_n != ST_WSTRB);
      mb_rd_n  <= (st_n != ST_RSTRB);
      mb_ad_oe <= (st_n == ST_LEAD) || (st_n == ST_ALE) || (st_n == ST_AHOLD) ||
                  (st_n == ST_WSTRB) || (st_n == ST_WTAIL);
      if ((st_n == ST_LEAD) || (st_n == ST_ALE) || (st_n == ST_AHOLD))
        mb_ad_out <= addr_n;
      else if ((st_n == ST_WSTRB) || (st_n == ST_WTAIL))
        mb_ad_out <= wdata_q;
      else
        mb_ad_out <= '0;
      rsp_done <= zero && ((st == ST_WTAIL) || (st == ST_RTAIL));
      if (zero && (st == ST_RTAIL))
        rsp_rdata <= mb_ad_in;
    end
  end

  // R6: at most one chip select active
  assert_one_cs_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(~mb_cs_n) <= 1);
  // R9: master never drives while the read strobe is low
  assert_bus_released_R9: assert property (@(posedge clk) disable iff (rst)
    !mb_rd_n |-> !mb_ad_oe);
  // R4: write data is driven under the write strobe
  assert_wdata_driven_R4: assert property (@(posedge clk) disable iff (rst)
    !mb_wr_n |-> mb_ad_oe);
  // R3: address strobe only inside a selected transaction
  assert_ale_selected_R3: assert property (@(posedge clk) disable iff (rst)
    mb_ale |-> (mb_cs_n != '1));
  // R2: strobes never overlap
  assert_strobes_apart_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mb_ale, !mb_rd_n, !mb_wr_n}));
  // R8: done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
  // R10: ready only while the bus is idle
  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mb_cs_n == '1));
endmodule

// File: rtl/phy_mbus_master.sv
module phy_mbus_master #(
  parameter int DATA_W      = 8,
  parameter int NUM_CS      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int CS_SU       = 2,
  parameter int ADDR_SU     = 3,
  parameter int ALE_W       = 2,
  parameter int ADDR_HOLD   = 1,
  parameter int WR_W        = 14,
  parameter int WR_RISE     = 18,
  parameter int WR_DSU      = 15,
  parameter int WR_DHOLD    = 1,
  parameter int WR_CS_RISE  = 20,
  parameter int WR_CS_W     = 22,
  parameter int RD_W        = 15,
  parameter int RD_RISE     = 20,
  parameter int RD_CS_RISE  = 18,
  parameter int RD_CS_W     = 20,
  localparam int CHIP_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CHIP_W-1:0] req_chip,
  input  logic [DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mb_ale,
  output logic [NUM_CS-1:0] mb_cs_n,
  output logic              mb_rd_n,
  output logic              mb_wr_n,
  output logic [DATA_W-1:0] mb_ad_out,
  output logic              mb_ad_oe,
  input  logic [DATA_W-1:0] mb_ad_in,
  input  logic              phy_rst_we,
  input  logic              phy_rst_val,
  output logic              phy_rst,
  input  logic              phy_int_in,
  output logic              phy_int
);

  mbus_seq #(
    .DATA_W(DATA_W), .NUM_CS(NUM_CS), .CHIP_W(CHIP_W),
    .CS_SU(CS_SU), .ADDR_SU(ADDR_SU), .ALE_W(ALE_W), .ADDR_HOLD(ADDR_HOLD),
    .WR_W(WR_W), .WR_RISE(WR_RISE), .WR_DSU(WR_DSU), .WR_DHOLD(WR_DHOLD),
    .WR_CS_RISE(WR_CS_RISE), .WR_CS_W(WR_CS_W),
    .RD_W(RD_W), .RD_RISE(RD_RISE), .RD_CS_RISE(RD_CS_RISE), .RD_CS_W(RD_CS_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_chip  (req_chip),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata),
    .mb_ale    (mb_ale),
    .mb_cs_n   (mb_cs_n),
    .mb_rd_n   (mb_rd_n),
    .mb_wr_n   (mb_wr_n),
    .mb_ad_out (mb_ad_out),
    .mb_ad_oe  (mb_ad_oe),
    .mb_ad_in  (mb_ad_in)
  );

  mbus_sync #(.STAGES(SYNC_STAGES)) u_int_sync (
    .clk (clk),
    .rst (rst),
    .d   (phy_int_in),
    .q   (phy_int)
  );

  // PHY reset level: asserted out of reset, changed only by an explicit load.
  always_ff @(posedge clk) begin
    if (rst)             phy_rst <= 1'b1;
    else if (phy_rst_we) phy_rst <= phy_rst_val;
  end

  // R11: reset level holds without a load
  assert_rst_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !phy_rst_we |=> $stable(phy_rst));
endmodule

// File: tb/phy_mbus_master_test.sv
module phy_mbus_master_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid, req_ready, req_write;
  logic [0:0] req_chip;
  logic [7:0] req_addr, req_wdata;
  logic       rsp_done;
  logic [7:0] rsp_rdata;
  logic       mb_ale, mb_rd_n, mb_wr_n, mb_ad_oe;
  logic [1:0] mb_cs_n;
  logic [7:0] mb_ad_out, mb_ad_in;
  logic       phy_rst_we, phy_rst_val, phy_rst, phy_int_in, phy_int;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  phy_mbus_master uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_chip(req_chip), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mb_ale(mb_ale), .mb_cs_n(mb_cs_n), .mb_rd_n(mb_rd_n), .mb_wr_n(mb_wr_n),
    .mb_ad_out(mb_ad_out), .mb_ad_oe(mb_ad_oe), .mb_ad_in(mb_ad_in),
    .phy_rst_we(phy_rst_we), .phy_rst_val(phy_rst_val), .phy_rst(phy_rst),
    .phy_int_in(phy_int_in), .phy_int(phy_int)
  );

  // PHY model and bus monitor
  logic [7:0] mem [0:511];
  logic       lat_chip;
  logic [7:0] lat_addr;
  int  m_ale, m_cs, m_cs_pre, m_wr, m_rd, m_both, m_oe_err, m_done;
  int  m_wr_rise, m_rd_rise, k;
  bit  fell;
  logic [7:0] m_addr_pre, m_addr_hold, m_wdata;
  logic m_hold_oe, p_ale = 1'b0, p_wr = 1'b1, p_rd = 1'b1;

  assign mb_ad_in = mb_ad_oe ? mb_ad_out :
                    ((mb_cs_n != 2'b11) ? mem[{lat_chip, lat_addr}] : 8'h00);

  task automatic mon_clear();
    m_ale = 0; m_cs = 0; m_cs_pre = 0; m_wr = 0; m_rd = 0; m_both = 0;
    m_oe_err = 0; m_done = 0; m_wr_rise = -1; m_rd_rise = -1; k = 0; fell = 0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (mb_ale) begin m_ale++; m_addr_pre = mb_ad_out; end
      if (mb_cs_n != 2'b11) m_cs++;
      if (mb_cs_n == 2'b00) m_both++;
      if (!mb_wr_n) begin m_wr++; if (!mb_ad_oe) m_oe_err++; end
      if (!mb_rd_n) begin m_rd++; if (mb_ad_oe) m_oe_err++; end
      if (p_ale && !mb_ale) begin
        fell = 1; k = 0;
        m_addr_hold = mb_ad_out; m_hold_oe = mb_ad_oe;
        lat_addr = mb_ad_out; lat_chip = !mb_cs_n[1];
      end else if (fell) k++;
      if (mb_cs_n != 2'b11 && !fell) m_cs_pre++;
      if (!p_wr && mb_wr_n) begin
        m_wr_rise = k; m_wdata = mb_ad_out;
        mem[{lat_chip, lat_addr}] = mb_ad_out;
      end
      if (!p_rd && mb_rd_n) m_rd_rise = k;
      if (rsp_done) m_done++;
      p_ale = mb_ale; p_wr = mb_wr_n; p_rd = mb_rd_n;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(bit wr, bit chip, logic [7:0] a, logic [7:0] d);
    req_valid = 1'b1; req_write = wr; req_chip = chip; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_done();
    while (!rsp_done) @(negedge clk);
  endtask

  task automatic xfer(bit wr, bit chip, logic [7:0] a, logic [7:0] d);
    mon_clear();
    issue(wr, chip, a, d);
    req_valid = 1'b0;
    wait_done();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 ready", req_ready, 1);
    check("R1 cs_n", mb_cs_n, 3);
    check("R1 ale", mb_ale, 0);
    check("R1 rd_n", mb_rd_n, 1);
    check("R1 wr_n", mb_wr_n, 1);
    check("R1 oe", mb_ad_oe, 0);
    check("R1 done", rsp_done, 0);
    check("R1 phy_rst", phy_rst, 1);
    check("R1 phy_int", phy_int, 0);
  endtask

  task automatic t_write_timing();
    xfer(1'b1, 1'b0, 8'h5A, 8'hC3);
    check("R2 ale width", m_ale, 2);
    check("R3 cs before ale fall", m_cs_pre, 3);
    check("R3 addr before fall", m_addr_pre, 8'h5A);
    check("R3 addr hold", m_addr_hold, 8'h5A);
    check("R3 addr hold oe", m_hold_oe, 1);
    check("R4 wr width", m_wr, 17);
    check("R4 wr rise after ale fall", m_wr_rise, 18);
    check("R4 wdata at wr rise", m_wdata, 8'hC3);
    check("R5 write cs width", m_cs, 23);
    check("R6 chip0 selected", lat_chip, 0);
    check("R6 no double select", m_both, 0);
    check("R8 done count", m_done, 1);
    check("R9 oe under strobes", m_oe_err, 0);
  endtask

  task automatic t_read_timing();
    xfer(1'b0, 1'b0, 8'h5A, 8'h00);
    check("R7 rdata", rsp_rdata, 8'hC3);
    check("R7 rd width", m_rd, 19);
    check("R7 rd rise after ale fall", m_rd_rise, 20);
    check("R5 read cs width", m_cs, 24);
    check("R9 bus released in read", m_oe_err, 0);
    check("R8 done count read", m_done, 1);
    check("R2 ale width read", m_ale, 2);
  endtask

  task automatic t_chip_select();
    xfer(1'b1, 1'b1, 8'h5A, 8'h3C);
    check("R6 chip1 selected", lat_chip, 1);
    xfer(1'b0, 1'b1, 8'h5A, 8'h00);
    check("R6 chip1 readback", rsp_rdata, 8'h3C);
    xfer(1'b0, 1'b0, 8'h5A, 8'h00);
    check("R6 chip0 untouched", rsp_rdata, 8'hC3);
    xfer(1'b1, 1'b0, 8'hFF, 8'h00);
    xfer(1'b0, 1'b0, 8'hFF, 8'h00);
    check("R7 zero data at top address", rsp_rdata, 8'h00);
  endtask

  task automatic t_back_to_back();
    mon_clear();
    issue(1'b1, 1'b0, 8'h11, 8'hA5);
    req_addr = 8'h22; req_wdata = 8'h5A; req_chip = 1'b1;
    check("R10 busy not ready", req_ready, 0);
    issue(1'b1, 1'b1, 8'h22, 8'h5A);
    req_valid = 1'b0;
    wait_done();
    @(negedge clk);
    check("R10 both done", m_done, 2);
    check("R10 both ale", m_ale, 4);
    check("R10 first write kept", mem[{1'b0, 8'h11}], 8'hA5);
    check("R10 second write kept", mem[{1'b1, 8'h22}], 8'h5A);
    check("R10 ready after done", req_ready, 1);
  endtask

  task automatic t_phy_reset();
    phy_rst_val = 1'b0; phy_rst_we = 1'b1;
    @(negedge clk);
    phy_rst_we = 1'b0; phy_rst_val = 1'b1;
    check("R11 cleared", phy_rst, 0);
    repeat (3) @(negedge clk);
    check("R11 held low", phy_rst, 0);
    phy_rst_we = 1'b1;
    @(negedge clk);
    phy_rst_we = 1'b0;
    check("R11 set", phy_rst, 1);
  endtask

  task automatic t_interrupt();
    phy_int_in = 1'b1;
    @(negedge clk);
    check("R12 after one edge", phy_int, 0);
    @(negedge clk);
    check("R12 after two edges", phy_int, 1);
    phy_int_in = 1'b0;
    @(negedge clk);
    check("R12 fall one edge", phy_int, 1);
    @(negedge clk);
    check("R12 fall two edges", phy_int, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_chip = 1'b0;
    req_addr = 8'h00; req_wdata = 8'h00;
    phy_rst_we = 1'b0; phy_rst_val = 1'b0; phy_int_in = 1'b0;
    mon_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_timing();
    t_read_timing();
    t_chip_select();
    t_back_to_back();
    t_phy_reset();
    t_interrupt();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule